// File: doc/BRIEF.md
# Activate Timing Checker

This block watches the command stream of a DRAM channel and says, every cycle, whether an activate may go to a requested rank and bank. Every issued command arrives on a single valid-qualified port with its type, rank and bank. The block holds the recovery state that those commands leave behind. A scheduler puts the rank and bank it wants to open on the request port and reads back `act_ok_o` in the same cycle.

Four recovery constraints are tracked. Two activates to the same rank must be spaced apart. A precharge delays the next activate to that bank, and a precharge-all delays the next activate to that rank. A refresh delays the next activate to that rank. A rolling window also limits each rank to four activates within a programmable number of clocks, and this window check has its own enable. All limits are configuration inputs counted in DRAM clocks. The result is the AND of every constraint that applies to the requested rank and bank.

Top module: `act_timing_chk`

## Requirements
- R1: While reset is asserted, and right after it, `act_ok_o` is high for every rank and bank, because all history is cleared.
- R2: After an activate to rank r in cycle t, an activate request to rank r in cycle t+k is allowed only when k >= `cfg_rrd_i` (the value sampled at issue). Other ranks are not affected.
- R3: After a precharge to rank r, bank b in cycle t, a request to that same rank and bank in cycle t+k is allowed only when k >= `cfg_rp_i` (sampled at issue). Other banks, including banks of the same rank, are not affected.
- R4: After a precharge-all to rank r in cycle t, any request to rank r in cycle t+k is allowed only when k >= `cfg_pall_i` (sampled at issue).
- R5: After a refresh to rank r in cycle t, any request to rank r in cycle t+k is allowed only when k >= `cfg_rfc_i` (9 bits, sampled at issue).
- R6: When `cfg_win_en_i` is high and a rank has four activates on record, a request to that rank is blocked while the oldest of those four is fewer than `cfg_win_len_i` cycles old. The block lifts in the cycle in which that age reaches `cfg_win_len_i`. The window length is applied live.
- R7: When `cfg_win_en_i` is low, the activate window never blocks a request, however many activates have been issued.
- R8: If a command of the same kind is issued to the same target while its recovery is still running, the recovery restarts from the newer command.
- R9: A programmed spacing of 0 or 1 imposes no restriction. `act_ok_o` is combinational from the stored state and the request, and it is high only when no constraint for the requested rank and bank is active.
- R10: A command is taken only when `cmd_valid_i` is high. `cmd_type_i` encodes 0 = activate, 1 = precharge, 2 = precharge-all, 3 = refresh. A command with `cmd_valid_i` low has no effect on any later answer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | DRAM command clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | An issued command is present this cycle |
| cmd_type_i | input | 2 | Command kind (see R10) |
| cmd_rank_i | input | RANK_W | Rank of the issued command |
| cmd_bank_i | input | BANK_W | Bank of the issued command |
| cfg_win_en_i | input | 1 | Enables the four-activate window check |
| cfg_win_len_i | input | 6 | Activate window length in clocks |
| cfg_rrd_i | input | 4 | Activate-to-activate spacing, same rank |
| cfg_rp_i | input | 4 | Precharge-to-activate spacing, same bank |
| cfg_pall_i | input | 4 | Precharge-all-to-activate spacing |
| cfg_rfc_i | input | 9 | Refresh-to-activate spacing |
| req_rank_i | input | RANK_W | Rank the scheduler wants to activate |
| req_bank_i | input | BANK_W | Bank the scheduler wants to activate |
| act_ok_o | output | 1 | Activate to the requested rank and bank is allowed |

## Verification
Single commands of each kind are issued in isolation, so that each spacing can be seen opening in its exact cycle. Each cycle, all sixteen rank and bank requests are swept, which separates the per-bank precharge state from the per-rank ones. Bursts of activates spaced two clocks apart fill the window with it enabled and then disabled, which tells the window limit apart from the activate spacing. Back-to-back refreshes show a restart rather than a merge. A long mixed stream of random commands, random valid gaps and configuration changes mid-flight covers the cases where constraints overlap and where a limit is sampled at issue rather than applied live.

// File: rtl/act_chk_pkg.sv
`timescale 1ns/1ps
package act_chk_pkg;
  typedef enum logic [1:0] {
    CMD_ACT    = 2'd0,
    CMD_PRE    = 2'd1,
    CMD_PREALL = 2'd2,
    CMD_REF    = 2'd3
  } dram_cmd_e;
endpackage

// File: rtl/act_recov_cnt.sv
`timescale 1ns/1ps
// Recovery down-counter: busy for VAL-1 cycles after the load cycle.
module act_recov_cnt #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         busy_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (load_i)           cnt_q <= (val_i == '0) ? '0 : val_i - W'(1);
    else if (cnt_q != '0)      cnt_q <= cnt_q - W'(1);
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/act_faw_track.sv
`timescale 1ns/1ps
// Sliding activate window: ages of the last SLOTS activates, slot 0 newest.
module act_faw_track #(
  parameter int SLOTS = 4,
  parameter int AGE_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             win_en_i,
  input  logic [AGE_W-1:0] win_len_i,
  output logic             block_o
);
  logic [AGE_W-1:0] age_q [SLOTS];
  logic [SLOTS-1:0] vld_q;

  function automatic logic [AGE_W-1:0] sat_inc(input logic [AGE_W-1:0] a);
    return (&a) ? a : a + AGE_W'(1);
  endfunction

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        age_q[i] <= '0;
        vld_q[i] <= 1'b0;
      end else if (push_i) begin
        if (i == 0) begin
          age_q[i] <= AGE_W'(1);
          vld_q[i] <= 1'b1;
        end else begin
          age_q[i] <= sat_inc(age_q[(i == 0) ? 0 : i-1]);
          vld_q[i] <= vld_q[(i == 0) ? 0 : i-1];
        end
      end else if (vld_q[i]) begin
        age_q[i] <= sat_inc(age_q[i]);
      end
    end
  end

  assign block_o = win_en_i && (&vld_q) && (age_q[SLOTS-1] < win_len_i);
endmodule

// File: rtl/act_timing_chk.sv
`timescale 1ns/1ps
module act_timing_chk #(
  parameter int NUM_RANKS = 2,
  parameter int NUM_BANKS = 8,
  parameter int WIN_SLOTS = 4,
  parameter int WIN_W     = 6,
  parameter int RRD_W     = 4,
  parameter int RP_W      = 4,
  parameter int PALL_W    = 4,
  parameter int RFC_W     = 9,
  localparam int RANK_W   = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_type_i,
  input  logic [RANK_W-1:0] cmd_rank_i,
  input  logic [BANK_W-1:0] cmd_bank_i,
  input  logic              cfg_win_en_i,
  input  logic [WIN_W-1:0]  cfg_win_len_i,
  input  logic [RRD_W-1:0]  cfg_rrd_i,
  input  logic [RP_W-1:0]   cfg_rp_i,
  input  logic [PALL_W-1:0] cfg_pall_i,
  input  logic [RFC_W-1:0]  cfg_rfc_i,
  input  logic [RANK_W-1:0] req_rank_i,
  input  logic [BANK_W-1:0] req_bank_i,
  output logic              act_ok_o
);
  import act_chk_pkg::*;

  dram_cmd_e cmd;
  assign cmd = dram_cmd_e'(cmd_type_i);

  logic [NUM_RANKS-1:0] rrd_busy, pall_busy, rfc_busy, faw_block;
  logic [NUM_RANKS-1:0][NUM_BANKS-1:0] rp_busy;

  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
    logic rank_hit;
    assign rank_hit = cmd_valid_i && (cmd_rank_i == RANK_W'(r));

    act_recov_cnt #(.W(RRD_W)) u_rrd (
      .clk_i, .rst_ni, .load_i(rank_hit && cmd == CMD_ACT),
      .val_i(cfg_rrd_i), .busy_o(rrd_busy[r])
    );
    act_recov_cnt #(.W(PALL_W)) u_pall (
      .clk_i, .rst_ni, .load_i(rank_hit && cmd == CMD_PREALL),
      .val_i(cfg_pall_i), .busy_o(pall_busy[r])
    );
    act_recov_cnt #(.W(RFC_W)) u_rfc (
      .clk_i, .rst_ni, .load_i(rank_hit && cmd == CMD_REF),
      .val_i(cfg_rfc_i), .busy_o(rfc_busy[r])
    );
    act_faw_track #(.SLOTS(WIN_SLOTS), .AGE_W(WIN_W)) u_faw (
      .clk_i, .rst_ni, .push_i(rank_hit && cmd == CMD_ACT),
      .win_en_i(cfg_win_en_i), .win_len_i(cfg_win_len_i), .block_o(faw_block[r])
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      act_recov_cnt #(.W(RP_W)) u_rp (
        .clk_i, .rst_ni,
        .load_i(rank_hit && cmd == CMD_PRE && cmd_bank_i == BANK_W'(b)),
        .val_i(cfg_rp_i), .busy_o(rp_busy[r][b])
      );
    end
  end

  assign act_ok_o = !(rrd_busy[req_rank_i] || pall_busy[req_rank_i] ||
                      rfc_busy[req_rank_i] || faw_block[req_rank_i] ||
                      rp_busy[req_rank_i][req_bank_i]);
endmodule

// File: rtl/act_timing_chk_sva.sv
`timescale 1ns/1ps
module act_timing_chk_sva #(
  parameter int RANK_W = 1,
  parameter int BANK_W = 3,
  parameter int RRD_W  = 4,
  parameter int RP_W   = 4,
  parameter int PALL_W = 4,
  parameter int RFC_W  = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_valid_i,
  input logic [1:0]        cmd_type_i,
  input logic [RANK_W-1:0] cmd_rank_i,
  input logic [BANK_W-1:0] cmd_bank_i,
  input logic [RRD_W-1:0]  cfg_rrd_i,
  input logic [RP_W-1:0]   cfg_rp_i,
  input logic [PALL_W-1:0] cfg_pall_i,
  input logic [RFC_W-1:0]  cfg_rfc_i,
  input logic [RANK_W-1:0] req_rank_i,
  input logic [BANK_W-1:0] req_bank_i,
  input logic              act_ok_o
);
  p_act_space_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_type_i == 2'd0 && cfg_rrd_i > RRD_W'(1))
    |=> (req_rank_i != $past(cmd_rank_i) || !act_ok_o));

  p_pre_space_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_type_i == 2'd1 && cfg_rp_i > RP_W'(1))
    |=> (req_rank_i != $past(cmd_rank_i) || req_bank_i != $past(cmd_bank_i) || !act_ok_o));

  p_pall_space_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_type_i == 2'd2 && cfg_pall_i > PALL_W'(1))
    |=> (req_rank_i != $past(cmd_rank_i) || !act_ok_o));

  p_ref_space_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_type_i == 2'd3 && cfg_rfc_i > RFC_W'(1))
    |=> (req_rank_i != $past(cmd_rank_i) || !act_ok_o));

  p_ok_known_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$isunknown(act_ok_o));
endmodule

bind act_timing_chk act_timing_chk_sva #(
  .RANK_W(RANK_W), .BANK_W(BANK_W), .RRD_W(RRD_W),
  .RP_W(RP_W), .PALL_W(PALL_W), .RFC_W(RFC_W)
) u_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i),
  .cmd_type_i(cmd_type_i), .cmd_rank_i(cmd_rank_i), .cmd_bank_i(cmd_bank_i),
  .cfg_rrd_i(cfg_rrd_i), .cfg_rp_i(cfg_rp_i), .cfg_pall_i(cfg_pall_i),
  .cfg_rfc_i(cfg_rfc_i), .req_rank_i(req_rank_i), .req_bank_i(req_bank_i),
  .act_ok_o(act_ok_o)
);

// File: tb/sim_act_timing_chk.sv
`timescale 1ns/1ps
module sim_act_timing_chk;
  localparam int NR = 2;
  localparam int NB = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_type = 2'd0;
  logic [0:0] cmd_rank = '0;
  logic [2:0] cmd_bank = '0;
  logic       win_en = 1'b0;
  logic [5:0] win_len = '0;
  logic [3:0] rrd = '0, rp = '0, pall = '0;
  logic [8:0] rfc = '0;
  logic [0:0] req_rank = '0;
  logic [2:0] req_bank = '0;
  logic       act_ok;

  always #4 clk = ~clk;

  act_timing_chk u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_type_i(cmd_type),
    .cmd_rank_i(cmd_rank), .cmd_bank_i(cmd_bank), .cfg_win_en_i(win_en),
    .cfg_win_len_i(win_len), .cfg_rrd_i(rrd), .cfg_rp_i(rp), .cfg_pall_i(pall),
    .cfg_rfc_i(rfc), .req_rank_i(req_rank), .req_bank_i(req_bank), .act_ok_o(act_ok)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  int last_act[NR], v_act[NR], last_pall[NR], v_pall[NR], last_ref[NR], v_ref[NR];
  int last_pre[NR][NB], v_pre[NR][NB];
  int hist[NR][4], hcnt[NR];

  task automatic model_reset();
    for (int r = 0; r < NR; r++) begin
      last_act[r] = -100000; v_act[r] = 0; last_pall[r] = -100000; v_pall[r] = 0;
      last_ref[r] = -100000; v_ref[r] = 0; hcnt[r] = 0;
      for (int b = 0; b < NB; b++) begin last_pre[r][b] = -100000; v_pre[r][b] = 0; end
    end
  endtask

  function automatic bit exp_ok(int r, int b, output string why);
    why = "R9";
    if (cyc - last_act[r] < v_act[r]) begin why = "R2"; return 1'b0; end
    if (cyc - last_pre[r][b] < v_pre[r][b]) begin why = "R3"; return 1'b0; end
    if (cyc - last_pall[r] < v_pall[r]) begin why = "R4"; return 1'b0; end
    if (cyc - last_ref[r] < v_ref[r]) begin why = "R5"; return 1'b0; end
    if (win_en && hcnt[r] == 4 && (cyc - hist[r][0]) < int'(win_len)) begin
      why = "R6"; return 1'b0;
    end
    return 1'b1;
  endfunction

  task automatic check_all(string tag);
    for (int r = 0; r < NR; r++) begin
      for (int b = 0; b < NB; b++) begin
        string why;
        bit e;
        req_rank = 1'(r); req_bank = 3'(b);
        #0.1;
        e = exp_ok(r, b, why);
        if (tag != "") why = tag;
        n_chk++;
        if (act_ok !== e) begin
          n_fail++;
          $display("FAIL %s rank=%0d bank=%0d cyc=%0d act_ok=%0b expected=%0b",
                   why, r, b, cyc, act_ok, e);
        end
      end
    end
  endtask

  task automatic model_update();
    int r;
    r = int'(cmd_rank);
    case (cmd_type)
      2'd0: begin
        last_act[r] = cyc; v_act[r] = int'(rrd);
        if (hcnt[r] == 4) begin
          for (int i = 0; i < 3; i++) hist[r][i] = hist[r][i+1];
          hist[r][3] = cyc;
        end else begin
          hist[r][hcnt[r]] = cyc; hcnt[r]++;
        end
      end
      2'd1: begin last_pre[r][cmd_bank] = cyc; v_pre[r][cmd_bank] = int'(rp); end
      2'd2: begin last_pall[r] = cyc; v_pall[r] = int'(pall); end
      default: begin last_ref[r] = cyc; v_ref[r] = int'(rfc); end
    endcase
  endtask

  // one clock: drive, sweep all requests, advance
  task automatic step(bit v, int t, int r, int b, string tag);
    cmd_valid = v; cmd_type = 2'(t); cmd_rank = 1'(r); cmd_bank = 3'(b);
    check_all(tag);
    @(posedge clk);
    if (v) model_update();
    cyc++;
    @(negedge clk);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) step(1'b0, 0, 0, 0, tag);
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired at cyc=%0d act_ok=%0b expected=done", cyc, act_ok);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    model_reset();
    repeat (2) @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    idle(3, "R1");

    rrd = 4'd5;
    step(1'b1, 0, 0, 2, "");            // R2: activate spacing
    idle(8, "");
    rp = 4'd6;
    step(1'b1, 1, 1, 3, "");            // R3: per-bank precharge
    idle(8, "");
    pall = 4'd7;
    step(1'b1, 2, 0, 0, "");            // R4
    idle(9, "");
    rfc = 9'd300;
    step(1'b1, 3, 1, 0, "");            // R5
    idle(305, "");

    rrd = 4'd0; win_en = 1'b1; win_len = 6'd20;  // R6 window
    for (int i = 0; i < 4; i++) begin step(1'b1, 0, 0, i, ""); idle(1, ""); end
    step(1'b1, 0, 1, 0, "");
    idle(14, "");
    step(1'b1, 0, 0, 5, "");
    idle(25, "");

    win_en = 1'b0;                      // R7 window disabled
    for (int i = 0; i < 6; i++) step(1'b1, 0, 1, i, "R7");
    idle(22, "R7");
    win_en = 1'b1;
    idle(3, "R6");

    rfc = 9'd10;                        // R8 restart
    step(1'b1, 3, 0, 0, "R8");
    idle(4, "R8");
    step(1'b1, 3, 0, 0, "R8");
    idle(12, "R8");

    rrd = 4'd8; rp = 4'd9;              // R10 invalid commands ignored
    for (int t = 0; t < 4; t++) step(1'b0, t, 1, 4, "R10");
    idle(4, "R10");

    rrd = 4'd1; rp = 4'd1; pall = 4'd0; rfc = 9'd1;  // R9 trivial spacings
    step(1'b1, 0, 0, 0, "R9");
    step(1'b1, 1, 0, 1, "R9");
    step(1'b1, 3, 1, 0, "R9");
    idle(2, "R9");

    for (int i = 0; i < 1500; i++) begin
      if (i % 50 == 0) begin
        rrd = 4'($urandom_range(0, 15)); rp = 4'($urandom_range(0, 15));
        pall = 4'($urandom_range(0, 15)); rfc = 9'($urandom_range(0, 40));
        win_len = 6'($urandom_range(0, 63)); win_en = 1'($urandom_range(0, 1));
      end
      step(1'($urandom_range(0, 1)), int'($urandom_range(0, 3)),
           int'($urandom_range(0, 1)), int'($urandom_range(0, 7)), "");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule